// File: doc/BRIEF.md
# Issue Group Sorter

This block looks at a window of up to three consecutive instruction words and decides how many of the leading words issue together as one group. Each word carries a two-bit kind (plain globule operation, control, pair lead or pair companion) and one bit that names the globule it targets. Plain groups keep the fixed order globule 1, globule 2, control, with any of these left out. A pair lead followed directly by its companion forms one coupled operation across both globules. A control word may follow the pair. The pair may start in either globule.

The decision logic is combinational. Its result goes into a registered output stage with a valid/ready handshake. The result gives the number of words consumed (1 to 3), a flag for a coupled pair, an illegal-group flag, and for each of the three slots (globule 1, globule 2, control) a valid bit and the window index of the word routed there. The fetch side shifts its window by the reported length and presents the next words.

Top module: `issue_group_sorter`

## Requirements
- R1: Word i of the window takes its kind from `win_op[2i+1:2i]`, with G=00, C=01, P=10 and Q=11, and its globule from `win_gsel[i]`, with 0 for globule 1 and 1 for globule 2. The globule bit of a C word has no effect.
- R2: A legal plain group is any non-empty ordered subset of G1, G2, C. For each word in the group, the matching slot valid bit is set and its index field holds the word's window position. An unused slot reports valid 0 and index 0.
- R3: Groups end greedily. The first word that cannot extend the group in the required order is left out and starts the next group, and `grp_len` counts only the words taken.
- R4: A P word followed directly by a Q word of the other globule forms a pair. The result sets `grp_pair`, has length 2, and fills both globule slots. P1 Q2 and P2 Q1 are both legal. A C word right after the pair joins the group, giving length 3 with the control index 2.
- R5: If the first word cannot start a legal group, `grp_illegal` is raised with length 1, no slot valid and `grp_pair` low. This covers a leading Q, a P not followed by a Q, and a P whose Q targets the same globule.
- R6: Only the first `win_cnt` words are considered. Missing words act as absent, and `win_cnt`=0 gives an illegal result of length 1.
- R7: An accepted window appears on the outputs in the cycle after acceptance. While `out_valid` is high and `out_ready` low, the outputs hold steady.
- R8: With FULL_THRU=1, `in_ready` equals `!out_valid || out_ready`. With FULL_THRU=0, it equals `!out_valid`.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: For every legal result, the number of valid slots equals `grp_len`, and a valid control slot always holds the last word of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window is presented |
| in_ready | output | 1 | Window can be taken this cycle |
| win_cnt | input | 2 | Number of words present in the window (0 to 3) |
| win_op | input | 6 | Two-bit kind of each word, word 0 in the low bits |
| win_gsel | input | 3 | Globule bit of each word |
| out_valid | output | 1 | Result is held |
| out_ready | input | 1 | Consumer takes the result |
| grp_illegal | output | 1 | First word cannot start a legal group |
| grp_pair | output | 1 | Group holds a coupled pair |
| grp_len | output | 2 | Words consumed, 1 to 3 |
| g1_vld | output | 1 | Globule 1 slot is used |
| g1_idx | output | 2 | Window index routed to globule 1 |
| g2_vld | output | 1 | Globule 2 slot is used |
| g2_idx | output | 2 | Window index routed to globule 2 |
| c_vld | output | 1 | Control slot is used |
| c_idx | output | 2 | Window index routed to the control slot |

## Verification
The bench builds the block with a three-word window and FULL_THRU=1. This lets a new window be accepted in the same cycle the previous result leaves, so back-to-back loads and stalls on the output side can both occur. A periodic `out_ready` stall pattern holds results over two cycles, which tests the R7 hold behaviour while the next window waits at the input. With this build, every plain and pair ordering can be reached, including the swapped pair, truncated windows and windows that end greedily. The FULL_THRU=0 variant is covered only by its checker property.

// File: rtl/igs_pkg.sv
package igs_pkg;

   localparam int IDX_W = 2;

   typedef enum logic [1:0] {
      OP_G = 2'b00,
      OP_C = 2'b01,
      OP_P = 2'b10,
      OP_Q = 2'b11
   } op_kind_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_G1,
      K_G2,
      K_C,
      K_P1,
      K_P2,
      K_Q1,
      K_Q2
   } word_kind_e;

   typedef struct packed {
      logic             illegal;
      logic             pair;
      logic [1:0]       len;
      logic             g1_vld;
      logic [IDX_W-1:0] g1_idx;
      logic             g2_vld;
      logic [IDX_W-1:0] g2_idx;
      logic             c_vld;
      logic [IDX_W-1:0] c_idx;
   } grp_res_t;

endpackage

// File: rtl/igs_word_class.sv
module igs_word_class
   import igs_pkg::*;
#(
   parameter int TYPE_W = 2
) (
   input  logic              present,
   input  logic [TYPE_W-1:0] op,
   input  logic              gsel,
   output word_kind_e        kind
);

   always_comb begin
      kind = K_NONE;
      if (present) begin
         unique case (op_kind_e'(op))
            OP_G: kind = gsel ? K_G2 : K_G1;
            OP_C: kind = K_C;
            OP_P: kind = gsel ? K_P2 : K_P1;
            OP_Q: kind = gsel ? K_Q2 : K_Q1;
            default: kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/igs_group_find.sv
module igs_group_find
   import igs_pkg::*;
(
   input  word_kind_e k0,
   input  word_kind_e k1,
   input  word_kind_e k2,
   output grp_res_t   res
);

   always_comb begin
      res     = '0;
      res.len = 2'd1;
      unique case (k0)
         K_G1: begin
            res.g1_vld = 1'b1;
            res.g1_idx = 2'd0;
            if (k1 == K_G2) begin
               res.g2_vld = 1'b1;
               res.g2_idx = 2'd1;
               res.len    = 2'd2;
               if (k2 == K_C) begin
                  res.c_vld = 1'b1;
                  res.c_idx = 2'd2;
                  res.len   = 2'd3;
               end
            end else if (k1 == K_C) begin
               res.c_vld = 1'b1;
               res.c_idx = 2'd1;
               res.len   = 2'd2;
            end
         end
         K_G2: begin
            res.g2_vld = 1'b1;
            res.g2_idx = 2'd0;
            if (k1 == K_C) begin
               res.c_vld = 1'b1;
               res.c_idx = 2'd1;
               res.len   = 2'd2;
            end
         end
         K_C: begin
            res.c_vld = 1'b1;
            res.c_idx = 2'd0;
         end
         K_P1, K_P2: begin
            if ((k0 == K_P1 && k1 == K_Q2) || (k0 == K_P2 && k1 == K_Q1)) begin
               res.pair   = 1'b1;
               res.g1_vld = 1'b1;
               res.g2_vld = 1'b1;
               res.g1_idx = (k0 == K_P1) ? 2'd0 : 2'd1;
               res.g2_idx = (k0 == K_P1) ? 2'd1 : 2'd0;
               res.len    = 2'd2;
               if (k2 == K_C) begin
                  res.c_vld = 1'b1;
                  res.c_idx = 2'd2;
                  res.len   = 2'd3;
               end
            end else begin
               res.illegal = 1'b1;
            end
         end
         default: res.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/igs_out_stage.sv
module igs_out_stage #(
   parameter int DW        = 13,
   parameter bit FULL_THRU = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);

   generate
      if (FULL_THRU) begin : g_full
         assign in_ready = !out_valid || out_ready;
      end else begin : g_half
         assign in_ready = !out_valid;
      end
   endgenerate

   wire take = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/issue_group_sorter.sv
module issue_group_sorter
   import igs_pkg::*;
#(
   parameter int WIN_WORDS = 3,
   parameter int TYPE_W    = 2,
   parameter bit FULL_THRU = 1'b1,
   localparam int CNT_W    = $clog2(WIN_WORDS + 1),
   localparam int OP_W     = WIN_WORDS * TYPE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [CNT_W-1:0] win_cnt,
   input  logic [OP_W-1:0]  win_op,
   input  logic [WIN_WORDS-1:0] win_gsel,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             grp_illegal,
   output logic             grp_pair,
   output logic [1:0]       grp_len,
   output logic             g1_vld,
   output logic [IDX_W-1:0] g1_idx,
   output logic             g2_vld,
   output logic [IDX_W-1:0] g2_idx,
   output logic             c_vld,
   output logic [IDX_W-1:0] c_idx
);

   localparam int RES_W = $bits(grp_res_t);

   generate
      if (WIN_WORDS != 3) begin : g_bad_win
         $error("issue_group_sorter: window must hold exactly three words");
      end
      if (TYPE_W != 2) begin : g_bad_type
         $error("issue_group_sorter: word kind field must be two bits");
      end
   endgenerate

   word_kind_e kinds [WIN_WORDS];

   for (genvar i = 0; i < WIN_WORDS; i++) begin : g_word
      logic present;
      assign present = (win_cnt > CNT_W'(i));
      igs_word_class #(.TYPE_W(TYPE_W)) u_class (
         .present (present),
         .op      (win_op[i*TYPE_W +: TYPE_W]),
         .gsel    (win_gsel[i]),
         .kind    (kinds[i])
      );
   end

   grp_res_t comb_res;
   grp_res_t held_res;

   igs_group_find u_find (
      .k0  (kinds[0]),
      .k1  (kinds[1]),
      .k2  (kinds[2]),
      .res (comb_res)
   );

   logic [RES_W-1:0] held_bits;

   igs_out_stage #(.DW(RES_W), .FULL_THRU(FULL_THRU)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (comb_res),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (held_bits)
   );

   assign held_res    = grp_res_t'(held_bits);
   assign grp_illegal = held_res.illegal;
   assign grp_pair    = held_res.pair;
   assign grp_len     = held_res.len;
   assign g1_vld      = held_res.g1_vld;
   assign g1_idx      = held_res.g1_idx;
   assign g2_vld      = held_res.g2_vld;
   assign g2_idx      = held_res.g2_idx;
   assign c_vld       = held_res.c_vld;
   assign c_idx       = held_res.c_idx;

endmodule

// File: rtl/igs_checker.sv
module igs_checker #(
   parameter bit FULL_THRU = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic [1:0] win_cnt,
   input logic       out_valid,
   input logic       out_ready,
   input logic       grp_illegal,
   input logic       grp_pair,
   input logic [1:0] grp_len,
   input logic       g1_vld,
   input logic [1:0] g1_idx,
   input logic       g2_vld,
   input logic [1:0] g2_idx,
   input logic       c_vld,
   input logic [1:0] c_idx
);

   wire [12:0] bundle = {grp_illegal, grp_pair, grp_len, g1_vld, g1_idx,
                         g2_vld, g2_idx, c_vld, c_idx};

   p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> grp_len != 2'd0);

   p_illegal_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && grp_illegal) |-> (grp_len == 2'd1 && !grp_pair && !g1_vld && !g2_vld && !c_vld));

   p_pair_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && grp_pair) |-> (g1_vld && g2_vld && g1_idx != g2_idx && !grp_illegal));

   p_plain_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !grp_pair && g1_vld && g2_vld) |-> (g1_idx < g2_idx));

   p_slot_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !grp_illegal) |-> ($countones({g1_vld, g2_vld, c_vld}) == int'(grp_len)));

   p_ctrl_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && c_vld) |-> (c_idx == grp_len - 2'd1));

   p_empty_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && win_cnt == 2'd0) |=> (out_valid && grp_illegal));

   p_load_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(bundle)));

   generate
      if (FULL_THRU) begin : g_full_chk
         p_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |-> !in_ready);
      end else begin : g_half_chk
         p_ready_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !in_ready);
      end
   endgenerate

endmodule

bind issue_group_sorter igs_checker #(.FULL_THRU(FULL_THRU)) u_igs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .win_cnt     (win_cnt),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .grp_illegal (grp_illegal),
   .grp_pair    (grp_pair),
   .grp_len     (grp_len),
   .g1_vld      (g1_vld),
   .g1_idx      (g1_idx),
   .g2_vld      (g2_vld),
   .g2_idx      (g2_idx),
   .c_vld       (c_vld),
   .c_idx       (c_idx)
);

// File: tb/tb_issue_group_sorter.sv
module tb_issue_group_sorter;

   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] TG = 2'b00, TC = 2'b01, TP = 2'b10, TQ = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [1:0] win_cnt = '0;
   logic [5:0] win_op = '0;
   logic [2:0] win_gsel = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic grp_illegal, grp_pair, g1_vld, g2_vld, c_vld;
   logic [1:0] grp_len, g1_idx, g2_idx, c_idx;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit stall_mode = 1'b0;
   bit done = 1'b0;

   logic [12:0] exp_q [$];
   string       tag_q [$];

   issue_group_sorter #(.FULL_THRU(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .win_cnt(win_cnt), .win_op(win_op), .win_gsel(win_gsel),
      .out_valid(out_valid), .out_ready(out_ready),
      .grp_illegal(grp_illegal), .grp_pair(grp_pair), .grp_len(grp_len),
      .g1_vld(g1_vld), .g1_idx(g1_idx), .g2_vld(g2_vld), .g2_idx(g2_idx),
      .c_vld(c_vld), .c_idx(c_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #2;
      out_ready = stall_mode ? ((cyc % 7) != 2 && (cyc % 7) != 3) : 1'b1;
   end

   function automatic logic [12:0] act_bits();
      return {grp_illegal, grp_pair, grp_len, g1_vld, g1_idx, g2_vld, g2_idx, c_vld, c_idx};
   endfunction

   function automatic logic [12:0] ex(bit ill, bit pr, logic [1:0] len,
                                      bit a, logic [1:0] ai, bit b, logic [1:0] bi,
                                      bit c, logic [1:0] ci);
      return {ill, pr, len, a, ai, b, bi, c, ci};
   endfunction

   function automatic logic [5:0] pk(logic [1:0] t0, logic [1:0] t1, logic [1:0] t2);
      return {t2, t1, t0};
   endfunction

   task automatic chk(bit ok, string req, logic [12:0] act, logic [12:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic send(logic [5:0] ops, logic [2:0] gs, logic [1:0] cnt,
                       logic [12:0] expv, string tag);
      bit acc = 1'b0;
      @(negedge clk);
      in_valid = 1'b1;
      win_op   = ops;
      win_gsel = gs;
      win_cnt  = cnt;
      while (!acc) begin
         #1;
         acc = in_ready;
         @(posedge clk);
         if (!acc) @(negedge clk);
      end
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      #1;
      chk(out_valid == 1'b1, "R7 latency", {12'd0, out_valid}, 13'd1);
   endtask

   // monitor / scoreboard
   bit          prev_stall = 1'b0;
   logic [12:0] prev_val = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (prev_stall)
            chk(out_valid && act_bits() == prev_val, "R7 hold", act_bits(), prev_val);
         chk(in_ready == (!out_valid || out_ready), "R8 ready",
             {12'd0, in_ready}, {12'd0, (!out_valid || out_ready)});
         prev_stall = out_valid && !out_ready;
         prev_val   = act_bits();
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected result", act_bits(), 13'd0);
            end else begin
               logic [12:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(act_bits() == e, t, act_bits(), e);
            end
         end
      end
   end

   task automatic run_list();
      send(pk(TG,TG,TC), 3'b010, 2'd3, ex(0,0,3,1,0,1,1,1,2), "R2 G1 G2 C");
      send(pk(TG,TG,TC), 3'b110, 2'd3, ex(0,0,3,1,0,1,1,1,2), "R1 C globule bit ignored");
      send(pk(TG,TG,TG), 3'b000, 2'd1, ex(0,0,1,1,0,0,0,0,0), "R2 G1 alone");
      send(pk(TG,TC,TG), 3'b001, 2'd3, ex(0,0,2,0,0,1,0,1,1), "R3 G2 C then G1");
      send(pk(TG,TC,TG), 3'b100, 2'd3, ex(0,0,2,1,0,0,0,1,1), "R3 G1 C then G2");
      send(pk(TC,TG,TG), 3'b100, 2'd3, ex(0,0,1,0,0,0,0,1,0), "R3 C ends group");
      send(pk(TG,TG,TC), 3'b001, 2'd3, ex(0,0,1,0,0,1,0,0,0), "R3 G2 then G1");
      send(pk(TG,TG,TC), 3'b000, 2'd3, ex(0,0,1,1,0,0,0,0,0), "R3 G1 then G1");
      send(pk(TG,TC,TC), 3'b001, 2'd3, ex(0,0,2,0,0,1,0,1,1), "R2 G2 C");
      send(pk(TP,TQ,TC), 3'b010, 2'd3, ex(0,1,3,1,0,1,1,1,2), "R4 P1 Q2 C");
      send(pk(TP,TQ,TG), 3'b001, 2'd2, ex(0,1,2,1,1,1,0,0,0), "R4 P2 Q1 short window");
      send(pk(TP,TQ,TG), 3'b001, 2'd3, ex(0,1,2,1,1,1,0,0,0), "R4 P2 Q1 then G1");
      send(pk(TP,TQ,TC), 3'b001, 2'd3, ex(0,1,3,1,1,1,0,1,2), "R4 P2 Q1 C");
      send(pk(TP,TQ,TC), 3'b000, 2'd3, ex(1,0,1,0,0,0,0,0,0), "R5 P1 Q1 same globule");
      send(pk(TP,TG,TC), 3'b010, 2'd3, ex(1,0,1,0,0,0,0,0,0), "R5 P1 without Q");
      send(pk(TQ,TG,TC), 3'b001, 2'd3, ex(1,0,1,0,0,0,0,0,0), "R5 leading Q");
      send(pk(TP,TQ,TC), 3'b010, 2'd1, ex(1,0,1,0,0,0,0,0,0), "R6 P cut by window");
      send(pk(TG,TG,TC), 3'b010, 2'd2, ex(0,0,2,1,0,1,1,0,0), "R6 C outside window");
      send(pk(TC,TC,TC), 3'b000, 2'd0, ex(1,0,1,0,0,0,0,0,0), "R6 empty window");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R9 reset out_valid actual=%b expected=0", out_valid);
      end
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R9 after reset actual=%b%b expected=01", out_valid, in_ready);
      end
      run_list();
      stall_mode = 1'b1;
      run_list();
      @(negedge clk);
      in_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule